// File: doc/BRIEF.md
# Per-Cell Voltage Alert Aggregator

This block gathers overvoltage (OV) and undervoltage (UV) alerts for a stack of battery cells, twelve by default. An external comparator stage supplies one raw OV bit and one raw UV bit per cell. A strobe marks the cycle in which a fresh measurement is complete. The block holds two host-writable enable masks, one for OV and one for UV. It also holds per-cell OV and UV status words, a per-cell combined alert word and two global summary flags.

The status is tiered. A host first looks at the global flags, which also appear as pins. It then reads the combined word to find the affected cells, and then the OV or UV word to see which condition applies. Status changes only when a measurement lands or when an enable bit is cleared. The host can never write the status directly.

Top module: `cell_alert_agg`

## Requirements
- R1: When rst_n is low, asynchronously and without waiting for a clock, both enable masks, both status words, the combined word and both global flags go to zero.
- R2: A write with wr_en high to address 0 loads the OV enable mask and to address 1 loads the UV enable mask. Both read back at their address on the following cycle.
- R3: In a cycle with meas_valid high, the OV status word at address 2 becomes raw_ov ANDed with the OV enable mask. The UV status word at address 3 becomes raw_uv ANDed with the UV enable mask. Both are visible after that clock edge.
- R4: In a cycle with meas_valid low, the raw inputs have no effect and each status bit whose enable is unchanged keeps its value.
- R5: Bit i of the combined alert word at address 4 is set exactly when bit i of the OV status or bit i of the UV status is set.
- R6: The summary word at address 5 has bit 0 equal to the OR of all OV status bits and bit 1 equal to the OR of all UV status bits, with all other bits zero. The pins any_ov and any_uv carry the same two flags.
- R7: Clearing an enable bit clears the matching status bit at the same clock edge that accepts the write, with no measurement needed. Setting an enable bit raises no status until the next measurement.
- R8: A write to any of addresses 2 to 7 changes no state. Addresses 6 and 7 always read zero.
- R9: An active alert clears at the next measurement whose raw bit for that cell is low.
- R10: When an enable write and a measurement fall in the same cycle, the measurement is masked with the newly written enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | High for one cycle when raw_ov and raw_uv hold a new measurement |
| raw_ov | input | NUM_CELLS | Per-cell overvoltage compare result |
| raw_uv | input | NUM_CELLS | Per-cell undervoltage compare result |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NUM_CELLS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NUM_CELLS | Register read data, combinational from rd_addr |
| any_ov | output | 1 | Global OV flag |
| any_uv | output | 1 | Global UV flag |

## Verification
The main capture path is driven with several hundred arithmetically generated pairs of enable masks and raw words. Some pairs give matching masks and raw bits, some disjoint, some all-ones and some single-cell. These show whether masking is done per cell and per condition, and whether OV and UV are kept apart. Cycles with meas_valid low and busy raw inputs separate a hold from a recapture. Enable clears without a measurement test R7's immediate drop. Back-to-back measurements whose raw bits fall test R9's clear path. A write coinciding with a measurement shows whether the old or the new mask is applied. All-ones writes to every read-only address show that status cannot be forced.

// File: rtl/cell_alert_pkg.sv
package cell_alert_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_OV_EN  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_UV_EN  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_OV_ST  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_UV_ST  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CELL   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_SUMM   = 3'd5;
  localparam int SUMM_OV_BIT = 0;
  localparam int SUMM_UV_BIT = 1;
endpackage

// File: rtl/alert_en_bank.sv
module alert_en_bank
  import cell_alert_pkg::*;
#(
  parameter int NUM_CELLS = 12,
  parameter logic [ADDR_W-1:0] SEL_ADDR = REG_OV_EN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_CELLS-1:0] wr_data,
  output logic [NUM_CELLS-1:0] en_d,
  output logic [NUM_CELLS-1:0] en_q
);
  logic hit;

  always_comb begin
    hit  = wr_en && (wr_addr == SEL_ADDR);
    en_d = hit ? wr_data : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (hit) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/alert_cell_slice.sv
module alert_cell_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_valid,
  input  logic raw_ov,
  input  logic raw_uv,
  input  logic ov_en_d,
  input  logic uv_en_d,
  output logic ov_st,
  output logic uv_st,
  output logic cell_alert
);
  logic ov_nxt, uv_nxt;
  logic ov_ce, uv_ce;

  // Capture on a measurement; otherwise only an enable clear may touch the bit.
  always_comb begin
    ov_nxt = (meas_valid ? raw_ov : ov_st) & ov_en_d;
    uv_nxt = (meas_valid ? raw_uv : uv_st) & uv_en_d;
    ov_ce  = meas_valid | (ov_st & ~ov_en_d);
    uv_ce  = meas_valid | (uv_st & ~uv_en_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_st <= 1'b0;
    end else if (ov_ce) begin
      ov_st <= ov_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_st <= 1'b0;
    end else if (uv_ce) begin
      uv_st <= uv_nxt;
    end
  end

  assign cell_alert = ov_st | uv_st;
endmodule

// File: rtl/alert_readout.sv
module alert_readout
  import cell_alert_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_CELLS-1:0] ov_en,
  input  logic [NUM_CELLS-1:0] uv_en,
  input  logic [NUM_CELLS-1:0] ov_st,
  input  logic [NUM_CELLS-1:0] uv_st,
  input  logic [NUM_CELLS-1:0] cell_alert,
  output logic [NUM_CELLS-1:0] rd_data,
  output logic                 any_ov,
  output logic                 any_uv
);
  logic [NUM_CELLS-1:0] summ;

  always_comb begin
    any_ov = |ov_st;
    any_uv = |uv_st;
    summ   = '0;
    summ[SUMM_OV_BIT] = any_ov;
    summ[SUMM_UV_BIT] = any_uv;
    case (rd_addr)
      REG_OV_EN: rd_data = ov_en;
      REG_UV_EN: rd_data = uv_en;
      REG_OV_ST: rd_data = ov_st;
      REG_UV_ST: rd_data = uv_st;
      REG_CELL:  rd_data = cell_alert;
      REG_SUMM:  rd_data = summ;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cell_alert_agg.sv
module cell_alert_agg
  import cell_alert_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_valid,
  input  logic [NUM_CELLS-1:0] raw_ov,
  input  logic [NUM_CELLS-1:0] raw_uv,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_CELLS-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_CELLS-1:0] rd_data,
  output logic                 any_ov,
  output logic                 any_uv
);
  logic [NUM_CELLS-1:0] ov_en_d, ov_en_q;
  logic [NUM_CELLS-1:0] uv_en_d, uv_en_q;
  logic [NUM_CELLS-1:0] ov_stat, uv_stat, cell_alert;

  alert_en_bank #(.NUM_CELLS(NUM_CELLS), .SEL_ADDR(REG_OV_EN)) u_ov_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_d(ov_en_d), .en_q(ov_en_q)
  );

  alert_en_bank #(.NUM_CELLS(NUM_CELLS), .SEL_ADDR(REG_UV_EN)) u_uv_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_d(uv_en_d), .en_q(uv_en_q)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    alert_cell_slice u_slice (
      .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
      .raw_ov(raw_ov[c]), .raw_uv(raw_uv[c]),
      .ov_en_d(ov_en_d[c]), .uv_en_d(uv_en_d[c]),
      .ov_st(ov_stat[c]), .uv_st(uv_stat[c]), .cell_alert(cell_alert[c])
    );
  end

  alert_readout #(.NUM_CELLS(NUM_CELLS)) u_rd (
    .rd_addr(rd_addr), .ov_en(ov_en_q), .uv_en(uv_en_q),
    .ov_st(ov_stat), .uv_st(uv_stat), .cell_alert(cell_alert),
    .rd_data(rd_data), .any_ov(any_ov), .any_uv(any_uv)
  );
endmodule

// File: rtl/cell_alert_agg_checker.sv
module cell_alert_agg_checker
  import cell_alert_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 meas_valid,
  input logic [NUM_CELLS-1:0] raw_ov,
  input logic [NUM_CELLS-1:0] raw_uv,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [NUM_CELLS-1:0] ov_en,
  input logic [NUM_CELLS-1:0] uv_en,
  input logic [NUM_CELLS-1:0] ov_st,
  input logic [NUM_CELLS-1:0] uv_st,
  input logic                 any_ov,
  input logic                 any_uv
);
  // R3 / R10: a measurement is masked with the enable in force after the edge
  a_r3_ov_capture: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> ov_st == ($past(raw_ov) & ov_en));
  a_r3_uv_capture: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> uv_st == ($past(raw_uv) & uv_en));

  // R4: without a measurement the status can only lose bits
  a_r4_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> ov_st == ($past(ov_st) & ov_en));

  // R7: no status bit survives without its enable
  a_r7_ov_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_st & ~ov_en) == '0);
  a_r7_uv_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_st & ~uv_en) == '0);

  // R8: writes to read-only addresses leave the status alone
  a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= REG_OV_ST && !meas_valid)
      |=> (ov_st == $past(ov_st)) && (uv_st == $past(uv_st)));

  // R6: global flags rise only after a measurement
  a_r6_ov_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_ov) |-> $past(meas_valid));
  a_r6_uv_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_uv) |-> $past(meas_valid));
endmodule

bind cell_alert_agg cell_alert_agg_checker #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
  .raw_ov(raw_ov), .raw_uv(raw_uv), .wr_en(wr_en), .wr_addr(wr_addr),
  .ov_en(ov_en_q), .uv_en(uv_en_q), .ov_st(ov_stat), .uv_st(uv_stat),
  .any_ov(any_ov), .any_uv(any_uv)
);

// File: tb/cell_alert_agg_bench.sv
`timescale 1ns/1ps
module cell_alert_agg_bench;
  localparam int N = 12;
  localparam logic [N-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         meas_valid;
  logic [N-1:0] raw_ov, raw_uv;
  logic         wr_en;
  logic [2:0]   wr_addr, rd_addr;
  logic [N-1:0] wr_data;
  logic [N-1:0] rd_data;
  logic         any_ov, any_uv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_oen, m_uen, m_ost, m_ust;

  always #5 clk = ~clk;

  cell_alert_agg #(.NUM_CELLS(N)) u_cell_alert_agg (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
    .raw_ov(raw_ov), .raw_uv(raw_uv), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .any_ov(any_ov), .any_uv(any_uv)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_reg(input int a);
    logic [N-1:0] s;
    s = '0;
    case (a)
      0: return m_oen;
      1: return m_uen;
      2: return m_ost;
      3: return m_ust;
      4: return m_ost | m_ust;
      5: begin s[0] = |m_ost; s[1] = |m_ust; return s; end
      default: return '0;
    endcase
  endfunction

  // read every address at mid-cycle and compare with the model
  task automatic check_all(input string ctx);
    string tags[8] = '{"R2 oen", "R2 uen", "R3 ost", "R3 ust", "R5 cell", "R6 summ", "R8 a6", "R8 a7"};
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk({ctx, " ", tags[a]}, rd_data, exp_reg(a));
    end
    chk({ctx, " R6 pins"}, {{(N-2){1'b0}}, any_uv, any_ov}, {{(N-2){1'b0}}, |m_ust, |m_ost});
  endtask

  // one clock: inputs driven at negedge, model updated for the edge that follows
  task automatic step(input logic mv, input logic [N-1:0] rov, input logic [N-1:0] ruv,
                      input logic we, input logic [2:0] wa, input logic [N-1:0] wd);
    meas_valid = mv; raw_ov = rov; raw_uv = ruv;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    if (we && wa == 3'd0) m_oen = wd;
    if (we && wa == 3'd1) m_uen = wd;
    if (mv) begin
      m_ost = rov & m_oen;
      m_ust = ruv & m_uen;
    end else begin
      m_ost = m_ost & m_oen;
      m_ust = m_ust & m_uen;
    end
    @(negedge clk);
    meas_valid = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; meas_valid = 1'b0; raw_ov = '0; raw_uv = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_oen = '0; m_uen = '0; m_ost = '0; m_ust = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 sweep of mask/raw patterns
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] oe, ue, ro, ru;
      oe = N'((k * 2731) ^ (k << 3));
      ue = N'((k * 1423) ^ 12'h5a5);
      ro = N'((k * 3989) + 7);
      ru = N'(~(k * 577));
      if (k % 50 == 0) begin oe = ALL1; ue = ALL1; ro = ALL1; ru = ALL1; end
      if (k % 50 == 1) begin oe = ALL1; ro = N'(1) << (k % N); ru = '0; end
      step(1'b0, '0, '0, 1'b1, 3'd0, oe);
      step(1'b0, '0, '0, 1'b1, 3'd1, ue);
      step(1'b1, ro, ru, 1'b0, 3'd0, '0);
      if (k % 10 == 0) check_all("R3 sweep");
      else begin
        rd_addr = 3'd2; #1; chk("R3 ov capture", rd_data, m_ost);
        rd_addr = 3'd3; #1; chk("R3 uv capture", rd_data, m_ust);
        rd_addr = 3'd4; #1; chk("R5 combined", rd_data, m_ost | m_ust);
      end
    end

    // R4: raw inputs busy without meas_valid
    step(1'b0, ALL1, ALL1, 1'b1, 3'd0, ALL1);
    step(1'b0, ALL1, ALL1, 1'b1, 3'd1, ALL1);
    step(1'b1, 12'h0f3, 12'h300, 1'b0, 3'd0, '0);
    for (int k = 0; k < 8; k++) step(1'b0, N'(k * 911), N'(~(k * 313)), 1'b0, 3'd0, '0);
    check_all("R4 hold");

    // R7: drop an enable bit, no measurement
    step(1'b0, '0, '0, 1'b1, 3'd0, 12'hffe);
    check_all("R7 clear drop");
    step(1'b0, '0, '0, 1'b1, 3'd0, ALL1);
    check_all("R7 set no raise");

    // R8: writes to read-only addresses
    for (int a = 2; a < 8; a++) begin
      step(1'b0, '0, '0, 1'b1, 3'(a), ALL1);
      check_all("R8 ro write");
    end

    // R9: conditions removed at next measurement
    step(1'b1, 12'h0f0, 12'h00f, 1'b0, 3'd0, '0);
    check_all("R9 set");
    step(1'b1, 12'h0c0, '0, 1'b0, 3'd0, '0);
    check_all("R9 partial clear");
    step(1'b1, '0, '0, 1'b0, 3'd0, '0);
    check_all("R9 all clear");

    // R10: enable write together with measurement
    step(1'b1, ALL1, ALL1, 1'b1, 3'd1, 12'h00a);
    check_all("R10 same cycle");
    step(1'b1, ALL1, ALL1, 1'b1, 3'd0, 12'h800);
    check_all("R10 same cycle ov");

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    m_oen = '0; m_uen = '0; m_ost = '0; m_ust = '0;
    check_all("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule